// File: doc/BRIEF.md
# Card Status Line Controller

This block drives the status lines a removable storage card presents to its host: a shared ready/interrupt line, an active-low status-changed line and a write-protect line. It tracks whether the card is still coming out of reset. Reset can come from a hardware pin, whose polarity depends on the bus personality, or from a soft-reset bit in an option register. The actual media start-up runs elsewhere and reports back through a single done strobe.

The block has three bus personalities, chosen by `modeSel`: memory (0), I/O (1) and disk-compatible (2). In memory mode the shared line is a ready/busy flag. In I/O mode it is an active-low interrupt request that can be a level or a fixed-width pulse. In disk-compatible mode it is an active-high level interrupt. Host writes to the option register and the status-enable register arrive as strobes with a two-bit data field. Interrupt requests and acknowledges come from the command logic.

Top module: `card_status_top`

## Requirements
- R1: In memory mode `rdyIrqOut` is 1 exactly when start-up is complete and `engineBusy` is 0. `engineBusy` acts in the same cycle.
- R2: After `rstN` low, a hardware reset or a soft reset, start-up is pending and `rdyIrqOut` is 0 in memory mode. Start-up completes one edge after `initDone` is seen while the hardware reset is not asserted. `initDone` has no effect while the hardware reset is asserted.
- R3: In I/O level mode, an edge with `irqRaise` high drives `rdyIrqOut` to 0. It stays 0 until an edge with `irqAck` high and `irqRaise` low.
- R4: In I/O pulse mode, each request drives `rdyIrqOut` low for exactly 4 cycles. A request that arrives during a pulse is held. It gets its own 4-cycle pulse after exactly one high cycle.
- R5: In disk-compatible mode `rdyIrqOut` is an active-high level interrupt, set by `irqRaise` and cleared by `irqAck`.
- R6: `resetPin` asserts reset when high in memory and I/O modes and when low in disk-compatible mode. A reset clears any pending or active interrupt at the next edge.
- R7: An option write (`optWrEn`) with `cfgData[1]`=1 sets the soft-reset bit at the next edge. The card becomes busy one edge later. The bit clears itself when start-up completes, so the card then stays ready.
- R8: In I/O mode `statChgN` is 0 when the status-enable bit is set and the {ready, write-protect} state has changed since the last clear. A status write (`stsWrEn`) takes its enable bit from `cfgData[0]`, and `cfgData[1]`=1 clears the change flag. `statChgN` is 1 in the other modes. Any reset clears the enable bit.
- R9: In memory mode `wpOut` is 1 while start-up is pending and 0 once it is complete. In the other modes `wpOut` is 1.
- R10: An option write takes the interrupt style from `cfgData[0]`: 1 selects pulse and 0 selects level. Any reset returns the style to level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| modeSel | input | 2 | Bus personality: 0 memory, 1 I/O, 2 disk-compatible |
| resetPin | input | 1 | Host hardware reset, polarity set by mode |
| initDone | input | 1 | Start-up complete strobe from the media logic |
| engineBusy | input | 1 | Command logic busy |
| irqRaise | input | 1 | Interrupt request strobe |
| irqAck | input | 1 | Interrupt acknowledge strobe |
| optWrEn | input | 1 | Option register write strobe |
| stsWrEn | input | 1 | Status-enable register write strobe |
| cfgData | input | 2 | Write data: bit 1 soft reset / clear flag, bit 0 pulse select / enable |
| rdyIrqOut | output | 1 | Ready/busy or interrupt line |
| statChgN | output | 1 | Status-changed, active low |
| wpOut | output | 1 | Write-protect indication |

## Verification
The bench builds the block with its default pulse width of 4. That keeps a full pulse, a held second request and the one-cycle gap between them inside a ten-cycle window, so each cycle of the pattern can be compared. It sweeps all three personalities for the reset-state pin values and for reset polarity. It also runs the soft reset, the status-change flag and the reversion to level style in the personalities where they matter.

// File: rtl/card_status_pkg.sv
package card_status_pkg;
  localparam logic [1:0] MODE_MEM  = 2'd0;
  localparam logic [1:0] MODE_IO   = 2'd1;
  localparam logic [1:0] MODE_DISK = 2'd2;

  localparam int CFG_W    = 2;
  localparam int BIT_HIGH = 1; // soft reset / clear flag
  localparam int BIT_LOW  = 0; // pulse select / enable

  typedef struct packed {
    logic resetReq;
    logic cardBusy;
    logic pulseMode;
    logic chgEnable;
    logic chgClear;
  } ctrlStb_t;
endpackage

// File: rtl/card_status_ctrl.sv
module card_status_ctrl
  import card_status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             resetPin,
  input  logic             initDone,
  input  logic             optWrEn,
  input  logic             stsWrEn,
  input  logic [CFG_W-1:0] cfgData,
  output ctrlStb_t         stb
);
  logic hwRst, softRst, initBusy, pulseSel, chgEn, resetReq, initFinish;

  // Hardware reset polarity follows the bus personality
  assign hwRst      = (modeSel == MODE_DISK) ? ~resetPin : resetPin;
  assign resetReq   = hwRst | softRst;
  assign initFinish = initBusy & initDone & ~hwRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initBusy <= 1'b1;
      softRst  <= 1'b0;
      pulseSel <= 1'b0;
      chgEn    <= 1'b0;
    end else begin
      if (initFinish)    initBusy <= 1'b0;
      else if (resetReq) initBusy <= 1'b1;

      if (initFinish)                      softRst <= 1'b0;
      else if (optWrEn && cfgData[BIT_HIGH]) softRst <= 1'b1;

      if (resetReq) begin
        pulseSel <= 1'b0;
        chgEn    <= 1'b0;
      end else begin
        if (optWrEn) pulseSel <= cfgData[BIT_LOW];
        if (stsWrEn) chgEn    <= cfgData[BIT_LOW];
      end
    end
  end

  always_comb begin
    stb.resetReq  = resetReq;
    stb.cardBusy  = initBusy;
    stb.pulseMode = pulseSel & (modeSel == MODE_IO);
    stb.chgEnable = chgEn;
    stb.chgClear  = stsWrEn & cfgData[BIT_HIGH];
  end
endmodule

// File: rtl/card_status_dp.sv
module card_status_dp
  import card_status_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  ctrlStb_t   stb,
  input  logic       engineBusy,
  input  logic       irqRaise,
  input  logic       irqAck,
  output logic       rdyIrqOut,
  output logic       statChgN,
  output logic       wpOut
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_V = CNT_W'(PULSE_LEN);

  logic             ready, wpState, irqLevel, pulsePend, chgFlag, pulseOn;
  logic [CNT_W-1:0] pulseCnt;
  logic [1:0]       curSt, prevSt;

  assign ready   = ~stb.cardBusy & ~engineBusy;
  assign wpState = stb.cardBusy;
  assign curSt   = {ready, wpState};
  assign pulseOn = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqLevel <= 1'b0;
    else if (stb.resetReq) irqLevel <= 1'b0;
    else if (irqRaise)     irqLevel <= 1'b1;
    else if (irqAck)       irqLevel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      pulsePend <= 1'b0;
    end else if (stb.resetReq || !stb.pulseMode) begin
      pulseCnt  <= '0;
      pulsePend <= 1'b0;
    end else if (pulseOn) begin
      pulseCnt <= pulseCnt - 1'b1;
      if (irqRaise) pulsePend <= 1'b1;
    end else if (irqRaise || pulsePend) begin
      pulseCnt  <= LEN_V;
      pulsePend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSt  <= 2'b01;
      chgFlag <= 1'b0;
    end else begin
      prevSt <= curSt;
      if (stb.resetReq)        chgFlag <= 1'b0;
      else if (curSt != prevSt) chgFlag <= 1'b1;
      else if (stb.chgClear)   chgFlag <= 1'b0;
    end
  end

  always_comb begin
    rdyIrqOut = ready;
    statChgN  = 1'b1;
    wpOut     = 1'b1;
    case (modeSel)
      MODE_IO: begin
        rdyIrqOut = stb.pulseMode ? ~pulseOn : ~irqLevel;
        statChgN  = ~(stb.chgEnable & chgFlag);
      end
      MODE_DISK: rdyIrqOut = irqLevel;
      default:   wpOut = wpState;
    endcase
  end
endmodule

// File: rtl/card_status_top.sv
module card_status_top
  import card_status_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             resetPin,
  input  logic             initDone,
  input  logic             engineBusy,
  input  logic             irqRaise,
  input  logic             irqAck,
  input  logic             optWrEn,
  input  logic             stsWrEn,
  input  logic [CFG_W-1:0] cfgData,
  output logic             rdyIrqOut,
  output logic             statChgN,
  output logic             wpOut
);
  ctrlStb_t ctrlStb;

  card_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .resetPin(resetPin),
    .initDone(initDone), .optWrEn(optWrEn), .stsWrEn(stsWrEn),
    .cfgData(cfgData), .stb(ctrlStb)
  );

  card_status_dp #(.PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .stb(ctrlStb),
    .engineBusy(engineBusy), .irqRaise(irqRaise), .irqAck(irqAck),
    .rdyIrqOut(rdyIrqOut), .statChgN(statChgN), .wpOut(wpOut)
  );
endmodule

// File: rtl/card_status_chk.sv
module card_status_chk
  import card_status_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       resetPin,
  input logic       rdyIrqOut,
  input logic       statChgN,
  input logic       wpOut,
  input logic       pulseMode,
  input logic       resetReq
);
  int lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowRun <= 0;
    else if (pulseMode && !rdyIrqOut) lowRun <= lowRun + 1;
    else                              lowRun <= 0;
  end

  AST_RESET_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_MEM && resetPin) |=> (!rdyIrqOut || modeSel != MODE_MEM)); // R2
  AST_DISK_RESET_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_DISK && !resetPin) |=> (!rdyIrqOut || modeSel != MODE_DISK)); // R6
  AST_PULSE_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= PULSE_LEN); // R4
  AST_CHG_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> statChgN); // R8
  AST_WP_CLEAR_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_MEM && rdyIrqOut) |-> !wpOut); // R9
endmodule

bind card_status_top card_status_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .resetPin(resetPin),
  .rdyIrqOut(rdyIrqOut), .statChgN(statChgN), .wpOut(wpOut),
  .pulseMode(ctrlStb.pulseMode), .resetReq(ctrlStb.resetReq)
);

// File: tb/test_card_status_top.sv
module test_card_status_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_LEN  = 4;

  logic clk = 0, rstN = 0, resetPin = 0, initDone = 0, engineBusy = 0;
  logic irqRaise = 0, irqAck = 0, optWrEn = 0, stsWrEn = 0;
  logic [1:0] modeSel = 0, cfgData = 0;
  logic rdyIrqOut, statChgN, wpOut;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_status_top #(.PULSE_LEN(PULSE_LEN)) i_card_status_top (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .resetPin(resetPin),
    .initDone(initDone), .engineBusy(engineBusy), .irqRaise(irqRaise),
    .irqAck(irqAck), .optWrEn(optWrEn), .stsWrEn(stsWrEn), .cfgData(cfgData),
    .rdyIrqOut(rdyIrqOut), .statChgN(statChgN), .wpOut(wpOut)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic resetLevel(logic [1:0] m);
    return (m == 2'd2) ? 1'b0 : 1'b1;
  endfunction

  task automatic hwReset(logic [1:0] m);
    resetPin = resetLevel(m);
    step(2);
    resetPin = ~resetLevel(m);
  endtask

  task automatic finishInit();
    initDone = 1; step(1); initDone = 0;
  endtask

  task automatic optWrite(logic [1:0] d);
    optWrEn = 1; cfgData = d; step(1); optWrEn = 0; cfgData = 0;
  endtask

  task automatic stsWrite(logic [1:0] d);
    stsWrEn = 1; cfgData = d; step(1); stsWrEn = 0; cfgData = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog all: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    check(rdyIrqOut, 1'b0, "R2", "busy after power-on");
    check(wpOut, 1'b1, "R9", "wp high after power-on");
    check(statChgN, 1'b1, "R8", "statChgN idle after power-on");

    // Sweep personalities: idle levels during and after reset
    for (int m = 0; m < 3; m++) begin
      modeSel = 2'(m);
      resetPin = ~resetLevel(2'(m));
      step(1);
      resetPin = resetLevel(2'(m));
      initDone = 1;            // ignored while hardware reset is asserted
      step(2);
      initDone = 0;
      resetPin = ~resetLevel(2'(m));
      step(2);
      check(wpOut, 1'b1, "R9", $sformatf("wp pending mode %0d", m));
      check(rdyIrqOut, (m == 1) ? 1'b1 : 1'b0, "R2",
            $sformatf("line while pending mode %0d", m));
      check(statChgN, 1'b1, "R8", $sformatf("statChgN mode %0d", m));
      finishInit();
      check(wpOut, (m == 0) ? 1'b0 : 1'b1, "R9", $sformatf("wp after init mode %0d", m));
      check(rdyIrqOut, (m == 1) ? 1'b1 : ((m == 0) ? 1'b1 : 1'b0), "R1",
            $sformatf("line after init mode %0d", m));
    end

    // R1: engine busy in memory mode
    modeSel = 0; #1;
    engineBusy = 1; #1;
    check(rdyIrqOut, 1'b0, "R1", "engine busy drops ready");
    engineBusy = 0; #1;
    check(rdyIrqOut, 1'b1, "R1", "engine idle restores ready");
    resetPin = 0; step(3);
    check(rdyIrqOut, 1'b1, "R6", "low reset pin idle in memory mode");

    // R3: I/O level interrupt
    modeSel = 1; step(1);
    irqRaise = 1; step(1); irqRaise = 0;
    check(rdyIrqOut, 1'b0, "R3", "level irq asserted");
    step(6);
    check(rdyIrqOut, 1'b0, "R3", "level irq held");
    irqAck = 1; step(1); irqAck = 0;
    check(rdyIrqOut, 1'b1, "R3", "level irq acked");

    // R4: pulse mode single request, exactly PULSE_LEN low cycles
    optWrite(2'b01);
    begin
      int lows = 0;
      irqRaise = 1; step(1); irqRaise = 0;
      for (int i = 0; i < 8; i++) begin
        if (!rdyIrqOut) lows++;
        step(1);
      end
      checks++;
      if (lows != PULSE_LEN) begin
        failures++;
        $display("FAIL R4 pulse width: actual=%0d expected=%0d", lows, PULSE_LEN);
      end
    end

    // R4: request during pulse is held and issued after one high cycle
    irqRaise = 1; step(1); irqRaise = 0;
    for (int i = 0; i < 10; i++) begin
      logic expLine;
      expLine = (i == 4 || i == 9) ? 1'b1 : 1'b0;
      check(rdyIrqOut, expLine, "R4", $sformatf("held pulse cycle %0d", i));
      if (i == 1) irqRaise = 1;
      step(1);
      irqRaise = 0;
    end

    // R10: reset returns to level style
    hwReset(1);
    finishInit();
    irqRaise = 1; step(1); irqRaise = 0;
    step(PULSE_LEN + 2);
    check(rdyIrqOut, 1'b0, "R10", "level style after reset");
    irqAck = 1; step(1); irqAck = 0;
    check(rdyIrqOut, 1'b1, "R6", "irq cleared by ack after reset");

    // R8: status-changed reporting
    stsWrite(2'b11);
    check(statChgN, 1'b1, "R8", "cleared and enabled");
    engineBusy = 1; step(1); engineBusy = 0;
    check(statChgN, 1'b0, "R8", "change reported");
    step(2);
    check(statChgN, 1'b0, "R8", "change flag held");
    modeSel = 0; #1;
    check(statChgN, 1'b1, "R8", "not reported in memory mode");
    modeSel = 1; #1;
    stsWrite(2'b00);
    check(statChgN, 1'b1, "R8", "disabled");
    stsWrite(2'b01);
    check(statChgN, 1'b0, "R8", "re-enabled shows pending change");
    hwReset(1);
    step(1);
    check(statChgN, 1'b1, "R8", "reset clears enable");
    finishInit();

    // R7: soft reset in memory mode
    modeSel = 0; step(1);
    optWrite(2'b10);
    check(rdyIrqOut, 1'b1, "R7", "ready one cycle after write");
    step(1);
    check(rdyIrqOut, 1'b0, "R7", "busy after soft reset");
    step(3);
    check(rdyIrqOut, 1'b0, "R7", "busy until init done");
    finishInit();
    check(rdyIrqOut, 1'b1, "R7", "ready after init");
    step(4);
    check(rdyIrqOut, 1'b1, "R7", "soft reset bit cleared itself");

    // R5 / R6: disk-compatible mode
    modeSel = 2; resetPin = 1; step(1);
    check(rdyIrqOut, 1'b0, "R5", "disk irq idle");
    irqRaise = 1; step(1); irqRaise = 0;
    check(rdyIrqOut, 1'b1, "R5", "disk irq active high");
    irqAck = 1; step(1); irqAck = 0;
    check(rdyIrqOut, 1'b0, "R5", "disk irq acked");
    irqRaise = 1; step(1); irqRaise = 0;
    resetPin = 0; step(1);
    check(rdyIrqOut, 1'b0, "R6", "low reset clears disk irq");
    resetPin = 1; finishInit();
    modeSel = 0; #1;
    check(rdyIrqOut, 1'b1, "R2", "ready after disk reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule